// File: doc/BRIEF.md
# Deep Single-Port Distributed RAM

This block is a single-port RAM, one to a few bits wide and 64 to 512 entries deep. Writes are synchronous and reads are asynchronous. It is built from small fixed storage cells, each 32 or 64 entries deep and one bit wide. Each cell has only its own address pins and one write-enable pin. A cell cannot decode any address bit above its own range.

The block handles the deeper range in soft logic. A decoder looks at the upper address bits and gives exactly one cell its write enable, gated by the block's write enable. A binary multiplexer tree, steered by the same upper bits, picks which cell drives the output. The low address bits go to every cell in parallel. A parameter selects whether writes happen on the rising or the falling clock edge. Typical shapes are 512x1, 256x2 and 128x4.

Top module: `dram_deep`

## Requirements
- R1: When `we` is high at the active clock edge, `din` is stored at `addr`. A later read of that address returns it.
- R2: `dout` follows `addr` combinationally, with no clock edge needed, and shows the entry at `addr`.
- R3: When `we` is low at the active edge, no entry changes, whatever `din` holds.
- R4: At most one storage cell in each bit column has its write enable active at any time.
- R5: No cell write enable is active while `we` is low.
- R6: During a write cycle, a read of the address being written shows the old value until the active edge and the new value after it.
- R7: Adjacent addresses on either side of a cell boundary (for example 63 and 64) are stored independently.
- R8: The lowest and highest addresses (0 and DEPTH-1) are stored independently.
- R9: With WIDTH above 1, each data bit is stored and read independently of the others.
- R10: With FALL_EDGE=1, writes take effect at the falling edge of `clk`. With FALL_EDGE=0, they take effect at the rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Write clock |
| we | input | 1 | Write enable |
| addr | input | $clog2(DEPTH) | Read and write address |
| din | input | WIDTH | Write data |
| dout | output | WIDTH | Asynchronous read data |

## Verification
The assertions run on every cycle. They check that the decoded cell enables are one-hot-or-zero and that all enables are silent when `we` is low. They also check that a write lands and a held address keeps its value. The last two checks apply only in the rising-edge build.

Only the bench scenarios can show the remaining behaviour. This covers a full readback against a reference array after random writes, and the independence of neighbours across the 63/64 and top/bottom boundaries. It also covers the old-then-new view at the write edge and the falling-edge variant.

// File: rtl/dram_cell.sv
module dram_cell #(
  parameter int CELL_DEPTH = 64,
  parameter bit FALL_EDGE  = 1'b0,
  localparam int CAW       = $clog2(CELL_DEPTH)
) (
  input  logic           clk,
  input  logic           we,
  input  logic [CAW-1:0] a,
  input  logic           d,
  output logic           q
);
  logic [CELL_DEPTH-1:0] bits = '0;

  generate
    if (FALL_EDGE) begin : g_fall
      always_ff @(negedge clk) if (we) bits[a] <= d;
    end else begin : g_rise
      always_ff @(posedge clk) if (we) bits[a] <= d;
    end
  endgenerate

  assign q = bits[a];
endmodule

// File: rtl/dram_deep.sv
module dram_deep #(
  parameter int DEPTH      = 512,
  parameter int CELL_DEPTH = 64,
  parameter int WIDTH      = 1,
  parameter bit FALL_EDGE  = 1'b0,
  localparam int AW        = $clog2(DEPTH),
  localparam int CAW       = $clog2(CELL_DEPTH),
  localparam int NCELL     = DEPTH / CELL_DEPTH,
  localparam int SELW      = AW - CAW,
  localparam int NODES     = 2 * NCELL - 1
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [NCELL-1:0] cell_we;
  logic [NODES-1:0] node [WIDTH];

  generate
    for (genvar c = 0; c < NCELL; c++) begin : g_dec
      if (NCELL == 1) begin : g_one
        assign cell_we[c] = we;
      end else begin : g_many
        assign cell_we[c] = we && (addr[AW-1:CAW] == SELW'(c));
      end
    end

    for (genvar w = 0; w < WIDTH; w++) begin : g_bit
      for (genvar c = 0; c < NCELL; c++) begin : g_cell
        dram_cell #(.CELL_DEPTH(CELL_DEPTH), .FALL_EDGE(FALL_EDGE)) u_cell (
          .clk (clk),
          .we  (cell_we[c]),
          .a   (addr[CAW-1:0]),
          .d   (din[w]),
          .q   (node[w][NCELL-1+c])
        );
      end
      for (genvar n = 0; n < NCELL - 1; n++) begin : g_mux
        localparam int LVL = $clog2(n + 2) - 1;
        assign node[w][n] = addr[CAW+SELW-1-LVL] ? node[w][2*n+2] : node[w][2*n+1];
      end
      assign dout[w] = node[w][0];
    end
  endgenerate

  always_comb begin
    a_r4_onehot_we: assert ($onehot0(cell_we));
    a_r5_idle_no_we: assert (we || cell_we == '0);
  end

  logic seen = 1'b0;
  always_ff @(posedge clk) seen <= 1'b1;

  generate
    if (!FALL_EDGE) begin : g_rise_chk
      a_r1_write_lands: assert property (@(posedge clk) disable iff (!seen)
        ($past(we) && addr == $past(addr)) |-> dout == $past(din));
      a_r3_hold_when_idle: assert property (@(posedge clk) disable iff (!seen)
        (!$past(we) && addr == $past(addr)) |-> dout == $past(dout));
    end
  endgenerate
endmodule

// File: tb/dram_deep_tb.sv
module dram_deep_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       we = 1'b0;
  logic [8:0] a1 = '0;
  logic       d1 = 1'b0;
  logic       q1;
  logic [7:0] a2 = '0;
  logic [1:0] d2 = '0;
  logic [1:0] q2;

  dram_deep u_dut (.clk(clk), .we(we), .addr(a1), .din(d1), .dout(q1));
  dram_deep #(.DEPTH(256), .CELL_DEPTH(32), .WIDTH(2), .FALL_EDGE(1'b1)) u_dut2 (
    .clk(clk), .we(we), .addr(a2), .din(d2), .dout(q2));

  logic       ref1 [512];
  logic [1:0] ref2 [256];
  int checks = 0;
  int errors = 0;

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic d, input logic [1:0] dd);
    @(posedge clk); #1;
    we = 1'b1; a1 = a; d1 = d; a2 = a[7:0]; d2 = dd;
    @(posedge clk); #1;
    we = 1'b0;
    ref1[a] = d;
    ref2[a[7:0]] = dd;
  endtask

  task automatic readback_all(input string req);
    for (int i = 0; i < 512; i++) begin
      a1 = 9'(i); a2 = 8'(i); #1;
      chk(req, {1'b0, q1}, {1'b0, ref1[i]});
      if (i < 256) chk(req, q2, ref2[i]);
    end
  endtask

  task automatic t_fill;
    for (int i = 0; i < 512; i++) wr(9'(i), 1'((i * 7) >> 2), 2'(i ^ (i >> 3)));
    readback_all("R1 R9 fill");
  endtask

  task automatic t_random;
    for (int i = 0; i < 400; i++) wr(9'($urandom), 1'($urandom), 2'($urandom));
    readback_all("R1 R9 random");
  endtask

  task automatic t_async;
    a1 = 9'd63; a2 = 8'd31; #1;
    chk("R2", {1'b0, q1}, {1'b0, ref1[63]});
    chk("R2", q2, ref2[31]);
    a1 = 9'd300; a2 = 8'd200; #1;
    chk("R2", {1'b0, q1}, {1'b0, ref1[300]});
    chk("R2", q2, ref2[200]);
  endtask

  task automatic t_boundary;
    wr(9'd63, 1'b1, 2'b01); wr(9'd64, 1'b0, 2'b10);
    wr(9'd511, 1'b1, 2'b11); wr(9'd0, 1'b0, 2'b00);
    wr(9'd31, 1'b0, 2'b11); wr(9'd32, 1'b1, 2'b00);
    wr(9'd255, 1'b0, 2'b01);
    a1 = 9'd63; #1;  chk("R7 63", {1'b0, q1}, 2'b01);
    a1 = 9'd64; #1;  chk("R7 64", {1'b0, q1}, 2'b00);
    a1 = 9'd511; #1; chk("R8 511", {1'b0, q1}, 2'b01);
    a1 = 9'd0; #1;   chk("R8 0", {1'b0, q1}, 2'b00);
    a2 = 8'd31; #1;  chk("R7 31", q2, 2'b11);
    a2 = 8'd32; #1;  chk("R7 32", q2, 2'b00);
    a2 = 8'd255; #1; chk("R8 255", q2, 2'b01);
    a2 = 8'd0; #1;   chk("R8 0w", q2, 2'b00);
  endtask

  task automatic t_we_low;
    for (int i = 0; i < 40; i++) begin
      @(posedge clk); #1;
      a1 = 9'($urandom); a2 = a1[7:0];
      d1 = ~ref1[a1]; d2 = ~ref2[a2];
    end
    @(posedge clk); #1;
    readback_all("R3 R5 we low");
  endtask

  task automatic t_edge;
    wr(9'd100, 1'b0, 2'b00);
    @(posedge clk); #1;
    we = 1'b1; a1 = 9'd100; d1 = 1'b1; a2 = 8'd100; d2 = 2'b10;
    #2;
    chk("R6 old before edge", {1'b0, q1}, 2'b00);
    chk("R6 R10 old before fall", q2, 2'b00);
    #4;
    chk("R10 fall written", q2, 2'b10);
    chk("R10 rise not yet", {1'b0, q1}, 2'b00);
    @(posedge clk); #1;
    we = 1'b0;
    chk("R6 new after edge", {1'b0, q1}, 2'b01);
    ref1[100] = 1'b1; ref2[100] = 2'b10;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_fill;
    t_async;
    t_random;
    t_boundary;
    t_we_low;
    t_edge;
    t_async;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule